// File: doc/BRIEF.md
# Recent Translation Cache

This block sits in front of a data-side translation lookaside buffer and remembers the two translations used most recently, so that a repeated access can be translated without running the full associative search and the privilege and mode decoding. Each of the two slots holds a copy of the page information of one buffer entry (aligned virtual base, page-size code, physical base, writable and side-effect attributes), the entry number, and the address-space identifier the access used. All slots share one snapshot of the processor's mode word, taken at the last fill.

A lookup presents the access address, byte size, address-space identifier, a write flag and the current mode word. One cycle later the block returns hit or miss, the slot that hit, the physical address and an uncacheable flag. On a miss the neighbouring logic performs the full translation and then presents the resulting entry on the fill port; fills keep the slots in most-recently-used order. Any change to the translation buffer (insert, demap or flush) is signalled by a single pulse that invalidates the whole cache.

Top module: `recent_xlate_cache`

## Requirements
- R1: After reset the cache holds nothing: no lookup hits until a fill has been accepted, and rsp_valid is low while no lookup is issued.
- R2: Every lookup (lk_valid high on a clock edge) produces exactly one response with rsp_valid high in the following cycle; no response appears without a lookup.
- R3: A slot hits only when the cache is valid, the slot is occupied, the stored mode word equals lk_mode, the slot identifier equals lk_asi, and the access range overlaps the slot's page. A miss returns rsp_hit, rsp_slot, rsp_pa and rsp_uncache all zero.
- R4: Overlap is tested on byte ranges: the access covers [lk_va, lk_va+lk_size) and the page covers [base, base+2^(13+3*pgsz)); an access that starts below the page but reaches into it hits, one that ends exactly at the page base misses.
- R5: A write lookup hits a slot only if that slot's page is writable; a read ignores the writable attribute.
- R6: On a hit the physical address is the slot's physical base with its page-offset bits replaced by the same bits of lk_va.
- R7: rsp_uncache is set on a hit when the page has its side-effect attribute or bit UC_BIT (default 39) of the physical address is set.
- R8: A fill of an entry number held in neither slot moves slot 0 into slot 1 (dropping the previous slot 1) and writes the new entry into slot 0; fl_mode becomes the mode snapshot.
- R9: A fill of an entry number already held in a slot leaves both slots, including their identifiers, unchanged.
- R10: A fill with fl_implicit set stores identifier zero in slot 0 regardless of fl_asi.
- R11: A tlb_change pulse invalidates the cache; no lookup hits until the next fill, and that fill first empties both slots so slot 1 stays empty.
- R12: A fill in the same cycle as tlb_change is discarded.
- R13: When both slots match, slot 0 wins and supplies the address and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Access virtual address |
| lk_size | input | SIZE_W | Access size in bytes |
| lk_asi | input | ASI_W | Address-space identifier of the access |
| lk_write | input | 1 | Access is a store |
| lk_mode | input | MODE_W | Current mode/state word |
| fl_valid | input | 1 | Fill request after a full lookup |
| fl_idx | input | IDX_W | Translation buffer entry number |
| fl_va | input | VA_W | Entry virtual address (aligned internally) |
| fl_pgsz | input | PGSZ_W | Page-size code, page is 2^(13+3*code) bytes |
| fl_pa | input | PA_W | Entry physical address (aligned internally) |
| fl_writable | input | 1 | Page allows writes |
| fl_sidefx | input | 1 | Page has side effects |
| fl_asi | input | ASI_W | Identifier the access used |
| fl_implicit | input | 1 | Access used an implicit identifier |
| fl_mode | input | MODE_W | Mode word to snapshot |
| tlb_change | input | 1 | Translation buffer was modified |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_slot | output | SEL_W | Slot that hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_uncache | output | 1 | Access must bypass caches |

## Verification
A lookup applied before a clock edge is answered by registered outputs right after that edge, so every response is due exactly one cycle after its request, while a fill or tlb_change applied at an edge first affects a lookup sampled at the next edge. The bench drives requests at the falling edge, pushes the expected response into a queue in the same step, and a monitor pops and compares at the following falling edge whenever rsp_valid is high, so a late, missing or extra response shows up as a mismatch or a leftover item. Fills are always separated from dependent lookups by at least one edge, which matches when state changes become visible.

// File: rtl/rxc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the recent translation cache.
// Assumes page sizes grow by a factor of eight per size code from 8 KiB.
package rxc_pkg;
    localparam int NSLOT         = 2;
    localparam int SEL_W         = 1;
    localparam int PG_BASE_SHIFT = 13;
    localparam int PG_STEP       = 3;

    // Number of page-offset bits for a given page-size code.
    function automatic int unsigned page_shift(input int unsigned code);
        return PG_BASE_SHIFT + PG_STEP * code;
    endfunction
endpackage

// File: rtl/rxc_slot_store.sv
`timescale 1ns/1ps
// Holds the two slots, the cache-valid flag and the mode snapshot.
// Applies fills in most-recently-used order and invalidation pulses.
// Assumes fl_* fields are stable for the cycle fl_valid is high.
module rxc_slot_store
    import rxc_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int ASI_W  = 8,
    parameter int MODE_W = 8,
    parameter int PGSZ_W = 2,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_valid,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [VA_W-1:0]   fl_va,
    input  logic [PGSZ_W-1:0] fl_pgsz,
    input  logic [PA_W-1:0]   fl_pa,
    input  logic              fl_writable,
    input  logic              fl_sidefx,
    input  logic [ASI_W-1:0]  fl_asi,
    input  logic              fl_implicit,
    input  logic [MODE_W-1:0] fl_mode,
    input  logic              tlb_change,
    output logic              cache_valid,
    output logic [MODE_W-1:0] mode_snap,
    output logic [NSLOT-1:0]  slot_occ,
    output logic [NSLOT-1:0]  slot_wr,
    output logic [NSLOT-1:0]  slot_sfx,
    output logic [VA_W-1:0]   slot_va   [NSLOT],
    output logic [PGSZ_W-1:0] slot_pgsz [NSLOT],
    output logic [PA_W-1:0]   slot_pa   [NSLOT],
    output logic [ASI_W-1:0]  slot_asi  [NSLOT]
);
    logic [IDX_W-1:0] slot_idx [NSLOT];
    logic [NSLOT-1:0] already_held;
    logic             accept;
    logic [VA_W-1:0]  fill_va_mask;
    logic [PA_W-1:0]  fill_pa_mask;
    logic [VA_W-1:0]  fill_va_base;
    logic [PA_W-1:0]  fill_pa_base;
    logic [ASI_W-1:0] fill_asi;

    // A fill coinciding with an invalidation is stale and is dropped.
    assign accept = fl_valid && !tlb_change;

    // Offset masks for the page being filled.
    assign fill_va_mask = ~({VA_W{1'b1}} << page_shift(int'(fl_pgsz)));
    assign fill_pa_mask = ~({PA_W{1'b1}} << page_shift(int'(fl_pgsz)));
    assign fill_va_base = fl_va & ~fill_va_mask;
    assign fill_pa_base = fl_pa & ~fill_pa_mask;
    assign fill_asi     = fl_implicit ? '0 : fl_asi;

    // Detect whether the filled entry already sits in a live slot.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_held
            assign already_held[s] = cache_valid && slot_occ[s] && (slot_idx[s] == fl_idx);
        end
    endgenerate

    // Slot state update: invalidate, empty-and-fill, or shift-and-fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_valid <= 1'b0;
            mode_snap   <= '0;
            slot_occ    <= '0;
            slot_wr     <= '0;
            slot_sfx    <= '0;
            for (int s = 0; s < NSLOT; s++) begin
                slot_idx[s]  <= '0;
                slot_va[s]   <= '0;
                slot_pgsz[s] <= '0;
                slot_pa[s]   <= '0;
                slot_asi[s]  <= '0;
            end
        end else if (tlb_change) begin
            cache_valid <= 1'b0;
        end else if (accept) begin
            cache_valid <= 1'b1;
            mode_snap   <= fl_mode;
            if (!(|already_held)) begin
                for (int s = NSLOT-1; s > 0; s--) begin
                    slot_occ[s]  <= cache_valid && slot_occ[s-1];
                    slot_wr[s]   <= slot_wr[s-1];
                    slot_sfx[s]  <= slot_sfx[s-1];
                    slot_idx[s]  <= slot_idx[s-1];
                    slot_va[s]   <= slot_va[s-1];
                    slot_pgsz[s] <= slot_pgsz[s-1];
                    slot_pa[s]   <= slot_pa[s-1];
                    slot_asi[s]  <= slot_asi[s-1];
                end
                slot_occ[0]  <= 1'b1;
                slot_wr[0]   <= fl_writable;
                slot_sfx[0]  <= fl_sidefx;
                slot_idx[0]  <= fl_idx;
                slot_va[0]   <= fill_va_base;
                slot_pgsz[0] <= fl_pgsz;
                slot_pa[0]   <= fill_pa_base;
                slot_asi[0]  <= fill_asi;
            end
        end
    end
endmodule

// File: rtl/rxc_slot_match.sv
`timescale 1ns/1ps
// Key comparison for one slot: validity, mode snapshot, identifier and
// byte-range overlap. Write permission is applied downstream.
// Assumes lk_size is small compared with the smallest page.
module rxc_slot_match
    import rxc_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int ASI_W  = 8,
    parameter int MODE_W = 8,
    parameter int SIZE_W = 4,
    parameter int PGSZ_W = 2
) (
    input  logic              cache_valid,
    input  logic [MODE_W-1:0] mode_snap,
    input  logic              occ,
    input  logic [VA_W-1:0]   base,
    input  logic [PGSZ_W-1:0] pgsz,
    input  logic [ASI_W-1:0]  asi,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [SIZE_W-1:0] lk_size,
    input  logic [ASI_W-1:0]  lk_asi,
    input  logic [MODE_W-1:0] lk_mode,
    output logic              key_hit
);
    logic [VA_W-1:0] off_mask;
    logic [VA_W:0]   acc_end;
    logic [VA_W:0]   pg_last;
    logic            overlap;

    // Page extent and access extent, one bit wider to avoid wrap.
    assign off_mask = ~({VA_W{1'b1}} << page_shift(int'(pgsz)));
    assign acc_end  = {1'b0, lk_va} + {{(VA_W+1-SIZE_W){1'b0}}, lk_size};
    assign pg_last  = {1'b0, base} + {1'b0, off_mask};

    // Ranges overlap when each starts before the other ends.
    assign overlap = ({1'b0, base} < acc_end) && (pg_last >= {1'b0, lk_va});

    // All key conditions together.
    assign key_hit = cache_valid && occ && (mode_snap == lk_mode) &&
                     (asi == lk_asi) && overlap;
endmodule

// File: rtl/rxc_resp.sv
`timescale 1ns/1ps
// Applies write permission, picks the lowest-numbered matching slot,
// composes the physical address and registers the response.
// Assumes VA_W is at least PA_W.
module rxc_resp
    import rxc_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int PGSZ_W = 2,
    parameter int UC_BIT = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [NSLOT-1:0]  key_hit,
    input  logic [NSLOT-1:0]  slot_wr,
    input  logic [NSLOT-1:0]  slot_sfx,
    input  logic [PGSZ_W-1:0] slot_pgsz [NSLOT],
    input  logic [PA_W-1:0]   slot_pa   [NSLOT],
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SEL_W-1:0]  rsp_slot,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_uncache
);
    logic [NSLOT-1:0] usable;
    logic             found;
    logic [SEL_W-1:0] sel;
    logic [PA_W-1:0]  pa_mask;
    logic [PA_W-1:0]  pa_next;
    logic             uc_next;

    // A slot is usable if its key matches and the write is permitted.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_use
            assign usable[s] = key_hit[s] && (!lk_write || slot_wr[s]);
        end
    endgenerate

    // Priority select: lowest slot number wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int s = NSLOT-1; s >= 0; s--) begin
            if (usable[s]) begin
                found = 1'b1;
                sel   = SEL_W'(s);
            end
        end
    end

    // Address composition and cacheability from the selected slot.
    assign pa_mask = ~({PA_W{1'b1}} << page_shift(int'(slot_pgsz[sel])));
    assign pa_next = slot_pa[sel] | (lk_va[PA_W-1:0] & pa_mask);
    assign uc_next = slot_sfx[sel] || pa_next[UC_BIT];

    // Response register: one cycle after the lookup, zeros on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_slot    <= '0;
            rsp_pa      <= '0;
            rsp_uncache <= 1'b0;
        end else begin
            rsp_valid   <= lk_valid;
            rsp_hit     <= lk_valid && found;
            rsp_slot    <= (lk_valid && found) ? sel : '0;
            rsp_pa      <= (lk_valid && found) ? pa_next : '0;
            rsp_uncache <= lk_valid && found && uc_next;
        end
    end
endmodule

// File: rtl/recent_xlate_cache.sv
`timescale 1ns/1ps
// Two-slot cache of recently used data translations.
// A lookup answers one cycle later; fills and invalidations take effect
// at the edge where they are sampled. Assumes VA_W >= PA_W > UC_BIT.
module recent_xlate_cache
    import rxc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 48,
    parameter int PA_W    = 40,
    parameter int ASI_W   = 8,
    parameter int MODE_W  = 8,
    parameter int SIZE_W  = 4,
    parameter int PGSZ_W  = 2,
    parameter int UC_BIT  = 39,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [SIZE_W-1:0] lk_size,
    input  logic [ASI_W-1:0]  lk_asi,
    input  logic              lk_write,
    input  logic [MODE_W-1:0] lk_mode,
    input  logic              fl_valid,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [VA_W-1:0]   fl_va,
    input  logic [PGSZ_W-1:0] fl_pgsz,
    input  logic [PA_W-1:0]   fl_pa,
    input  logic              fl_writable,
    input  logic              fl_sidefx,
    input  logic [ASI_W-1:0]  fl_asi,
    input  logic              fl_implicit,
    input  logic [MODE_W-1:0] fl_mode,
    input  logic              tlb_change,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SEL_W-1:0]  rsp_slot,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_uncache
);
    logic              cache_valid;
    logic [MODE_W-1:0] mode_snap;
    logic [NSLOT-1:0]  slot_occ;
    logic [NSLOT-1:0]  slot_wr;
    logic [NSLOT-1:0]  slot_sfx;
    logic [VA_W-1:0]   slot_va   [NSLOT];
    logic [PGSZ_W-1:0] slot_pgsz [NSLOT];
    logic [PA_W-1:0]   slot_pa   [NSLOT];
    logic [ASI_W-1:0]  slot_asi  [NSLOT];
    logic [NSLOT-1:0]  key_hit;

    rxc_slot_store #(
        .VA_W(VA_W), .PA_W(PA_W), .ASI_W(ASI_W), .MODE_W(MODE_W),
        .PGSZ_W(PGSZ_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fl_valid(fl_valid), .fl_idx(fl_idx), .fl_va(fl_va),
        .fl_pgsz(fl_pgsz), .fl_pa(fl_pa), .fl_writable(fl_writable),
        .fl_sidefx(fl_sidefx), .fl_asi(fl_asi), .fl_implicit(fl_implicit),
        .fl_mode(fl_mode), .tlb_change(tlb_change),
        .cache_valid(cache_valid), .mode_snap(mode_snap),
        .slot_occ(slot_occ), .slot_wr(slot_wr), .slot_sfx(slot_sfx),
        .slot_va(slot_va), .slot_pgsz(slot_pgsz), .slot_pa(slot_pa),
        .slot_asi(slot_asi)
    );

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_match
            rxc_slot_match #(
                .VA_W(VA_W), .ASI_W(ASI_W), .MODE_W(MODE_W),
                .SIZE_W(SIZE_W), .PGSZ_W(PGSZ_W)
            ) u_match (
                .cache_valid(cache_valid), .mode_snap(mode_snap),
                .occ(slot_occ[s]), .base(slot_va[s]), .pgsz(slot_pgsz[s]),
                .asi(slot_asi[s]), .lk_va(lk_va), .lk_size(lk_size),
                .lk_asi(lk_asi), .lk_mode(lk_mode), .key_hit(key_hit[s])
            );
        end
    endgenerate

    rxc_resp #(
        .VA_W(VA_W), .PA_W(PA_W), .PGSZ_W(PGSZ_W), .UC_BIT(UC_BIT)
    ) u_resp (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_va(lk_va),
        .key_hit(key_hit), .slot_wr(slot_wr), .slot_sfx(slot_sfx),
        .slot_pgsz(slot_pgsz), .slot_pa(slot_pa),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot),
        .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache)
    );
endmodule

// File: rtl/rxc_checker.sv
`timescale 1ns/1ps
// Temporal checks for the recent translation cache, bound to the top.
module rxc_checker
    import rxc_pkg::*;
#(
    parameter int PA_W   = 40,
    parameter int UC_BIT = 39
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_write,
    input logic             fl_valid,
    input logic             tlb_change,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [SEL_W-1:0] rsp_slot,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_uncache,
    input logic [NSLOT-1:0] key_hit,
    input logic [NSLOT-1:0] slot_wr,
    input logic             occ0
);
    logic stale;

    // Tracks whether the cache has been refilled since the last change.
    always_ff @(posedge clk) begin
        if (!rst_n)          stale <= 1'b1;
        else if (tlb_change) stale <= 1'b1;
        else if (fl_valid)   stale <= 1'b0;
    end

    a_r2_rsp_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R1, R11, R12: nothing hits before a fill accepted after a change.
    a_r11_stale_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && stale) |=> !rsp_hit);
    a_r5_write_needs_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_write && !(|(key_hit & slot_wr))) |=> !rsp_hit);
    a_r7_pa_bit_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_pa[UC_BIT]) |-> rsp_uncache);
    a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_uncache && rsp_slot == '0));
    a_r8_fill_occupies_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !tlb_change) |=> occ0);
endmodule

bind recent_xlate_cache rxc_checker #(.PA_W(PA_W), .UC_BIT(UC_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .fl_valid(fl_valid), .tlb_change(tlb_change), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_slot(rsp_slot), .rsp_pa(rsp_pa),
    .rsp_uncache(rsp_uncache), .key_hit(key_hit), .slot_wr(slot_wr),
    .occ0(slot_occ[0])
);

// File: tb/recent_xlate_cache_bench.sv
`timescale 1ns/1ps
module recent_xlate_cache_bench;
    localparam int VA_W = 48, PA_W = 40, ASI_W = 8, MODE_W = 8;
    localparam int SIZE_W = 4, PGSZ_W = 2, IDX_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [SIZE_W-1:0] lk_size = '0;
    logic [ASI_W-1:0]  lk_asi = '0;
    logic              lk_write = 1'b0;
    logic [MODE_W-1:0] lk_mode = '0;
    logic              fl_valid = 1'b0;
    logic [IDX_W-1:0]  fl_idx = '0;
    logic [VA_W-1:0]   fl_va = '0;
    logic [PGSZ_W-1:0] fl_pgsz = '0;
    logic [PA_W-1:0]   fl_pa = '0;
    logic              fl_writable = 1'b0;
    logic              fl_sidefx = 1'b0;
    logic [ASI_W-1:0]  fl_asi = '0;
    logic              fl_implicit = 1'b0;
    logic [MODE_W-1:0] fl_mode = '0;
    logic              tlb_change = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_uncache;
    logic [0:0]        rsp_slot;
    logic [PA_W-1:0]   rsp_pa;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic            hit;
        logic [0:0]      slot;
        logic [PA_W-1:0] pa;
        logic            uc;
    } exp_t;
    exp_t  q_exp[$];
    string q_tag[$];

    recent_xlate_cache u_recent_xlate_cache (.*);

    always #4 clk = ~clk;

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response hit=%0b pa=%h expected none", rsp_hit, rsp_pa);
            end else begin
                exp_t e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if ({rsp_hit, rsp_slot, rsp_pa, rsp_uncache} !== e) begin
                    errors++;
                    $display("FAIL %s actual hit=%0b slot=%0d pa=%h uc=%0b expected hit=%0b slot=%0d pa=%h uc=%0b",
                             t, rsp_hit, rsp_slot, rsp_pa, rsp_uncache, e.hit, e.slot, e.pa, e.uc);
                end
            end
        end
    end

    // Driver: issue one lookup and queue its expected response.
    task automatic look(input logic [VA_W-1:0] va, input int sz, input logic [ASI_W-1:0] asi,
                        input bit wr, input logic [MODE_W-1:0] mode, input bit h, input bit sl,
                        input logic [PA_W-1:0] pa, input bit uc, input string tag);
        lk_valid = 1'b1; lk_va = va; lk_size = SIZE_W'(sz); lk_asi = asi;
        lk_write = wr; lk_mode = mode;
        q_exp.push_back({h, sl, pa, uc});
        q_tag.push_back(tag);
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    // Driver: present one fill, optionally together with a change pulse.
    task automatic fill(input int idx, input logic [VA_W-1:0] va, input int pg,
                        input logic [PA_W-1:0] pa, input bit wr, input bit sfx,
                        input logic [ASI_W-1:0] asi, input bit impl, input bit chg);
        fl_valid = 1'b1; fl_idx = IDX_W'(idx); fl_va = va; fl_pgsz = PGSZ_W'(pg);
        fl_pa = pa; fl_writable = wr; fl_sidefx = sfx; fl_asi = asi;
        fl_implicit = impl; fl_mode = 8'h05; tlb_change = chg;
        @(negedge clk);
        fl_valid = 1'b0; tlb_change = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset rsp_valid actual %0b expected 0", rsp_valid);
        end
        look(48'h0000_2000_0123, 4, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R1 empty after reset");

        fill(3, 48'h0000_2000_0456, 0, 40'h00_4000_6789, 0, 0, 8'h80, 0, 0);
        look(48'h0000_2000_0123, 4, 8'h80, 0, 8'h05, 1, 0, 40'h00_4000_6123, 0, "R6 R3 basic hit");
        look(48'h0000_2000_0123, 4, 8'h81, 0, 8'h05, 0, 0, '0, 0, "R3 asi mismatch");
        look(48'h0000_2000_0123, 4, 8'h80, 0, 8'h06, 0, 0, '0, 0, "R3 mode mismatch");
        look(48'h0000_2000_0123, 4, 8'h80, 1, 8'h05, 0, 0, '0, 0, "R5 write to read-only");
        look(48'h0000_2000_2000, 1, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R4 past page end");
        look(48'h0000_1FFF_FFFC, 8, 8'h80, 0, 8'h05, 1, 0, 40'h00_4000_7FFC, 0, "R4 reaches into page");
        look(48'h0000_1FFF_FFFC, 4, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R4 ends at page base");

        fill(7, 48'h0000_3000_0000, 1, 40'h80_0001_0000, 1, 0, 8'h80, 0, 0);
        look(48'h0000_3000_ABCD, 1, 8'h80, 1, 8'h05, 1, 0, 40'h80_0001_ABCD, 1, "R7 R5 pa bit uncached write");
        look(48'h0000_2000_0010, 4, 8'h80, 0, 8'h05, 1, 1, 40'h00_4000_6010, 0, "R8 shifted to slot1");

        fill(9, 48'h0000_5000_0000, 0, 40'h00_0000_A000, 0, 1, 8'h04, 1, 0);
        look(48'h0000_5000_0004, 4, 8'h00, 0, 8'h05, 1, 0, 40'h00_0000_A004, 1, "R10 R7 implicit asi zero");
        look(48'h0000_5000_0004, 4, 8'h04, 0, 8'h05, 0, 0, '0, 0, "R10 given asi not stored");
        look(48'h0000_2000_0010, 4, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R8 oldest evicted");
        look(48'h0000_3000_0000, 2, 8'h80, 0, 8'h05, 1, 1, 40'h80_0001_0000, 1, "R8 slot1 after shift");

        fill(7, 48'h0000_3000_0000, 1, 40'h80_0001_0000, 1, 0, 8'h99, 0, 0);
        look(48'h0000_3000_0004, 4, 8'h80, 0, 8'h05, 1, 1, 40'h80_0001_0004, 1, "R9 refill keeps slot");
        look(48'h0000_3000_0004, 4, 8'h99, 0, 8'h05, 0, 0, '0, 0, "R9 refill asi ignored");
        look(48'h0000_5000_0004, 4, 8'h00, 0, 8'h05, 1, 0, 40'h00_0000_A004, 1, "R9 slot0 unchanged");

        fill(12, 48'h0000_5000_0000, 0, 40'h00_0000_C000, 1, 0, 8'h00, 0, 0);
        look(48'h0000_5000_0008, 4, 8'h00, 0, 8'h05, 1, 0, 40'h00_0000_C008, 0, "R13 slot0 priority");
        look(48'h0000_5000_0008, 4, 8'h00, 1, 8'h05, 1, 0, 40'h00_0000_C008, 0, "R5 writable slot hit");

        tlb_change = 1'b1;
        @(negedge clk);
        tlb_change = 1'b0;
        look(48'h0000_5000_0008, 4, 8'h00, 0, 8'h05, 0, 0, '0, 0, "R11 no hit after change");
        fill(3, 48'h0000_2000_0000, 0, 40'h00_4000_6000, 0, 0, 8'h80, 0, 0);
        look(48'h0000_2000_0123, 4, 8'h80, 0, 8'h05, 1, 0, 40'h00_4000_6123, 0, "R11 refill hits");
        look(48'h0000_5000_0008, 4, 8'h00, 0, 8'h05, 0, 0, '0, 0, "R11 slot1 emptied");

        fill(20, 48'h0000_7000_0000, 0, 40'h00_0000_E000, 0, 0, 8'h80, 0, 1);
        look(48'h0000_7000_0000, 4, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R12 fill dropped");
        look(48'h0000_2000_0123, 4, 8'h80, 0, 8'h05, 0, 0, '0, 0, "R12 cache invalid");

        repeat (3) @(negedge clk);
        checks++;
        if (q_exp.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses actual %0d pending expected 0", q_exp.size());
        end
        finish_run();
    end
endmodule